// File: doc/BRIEF.md
# Single-Parity-Check Constituent Decoder

This block decodes a single-parity-check constituent code of length `NV` (a power of two, at least 4) taken from one node of a polar decoding tree. It receives the node's whole vector of signed log-likelihood ratios in one transfer and returns the maximum-likelihood codeword estimate. Every bit starts as the hard decision of its LLR. If the XOR of those decisions is odd, the bit whose LLR has the smallest magnitude is inverted. The least reliable position is found by a compare-and-select tree.

The parameter `P` sets how many LLRs the selection tree examines per cycle. When `NV <= P`, the whole node is handled in one pass and the estimate is registered on the accepting clock edge. When `NV > P`, the block captures the vector, scans it `P` entries per cycle while it keeps a running minimum and parity, and then spends one cycle on the correction. The input side uses a valid/ready handshake. The output is a one-cycle valid pulse with the codeword.

Top module: `spc_decoder`

## Requirements
- R1: The hard decision of LLR i (lanes `in_llr[i*LLR_W +: LLR_W]`, two's complement) is 0 when the LLR is zero or positive and 1 when it is negative. Output bit `out_code[i]` belongs to LLR i.
- R2: Every output codeword has even parity: the XOR of all `NV` bits of `out_code` is 0.
- R3: The output differs from the hard-decision vector in at most one bit. When the hard decisions already have even parity, the output equals them exactly.
- R4: When the hard decisions have odd parity, the single inverted bit is at the index of the smallest LLR magnitude, wherever that index lies in the vector.
- R5: Among equal smallest magnitudes, the lowest index is inverted.
- R6: The magnitude of the most negative LLR value saturates to the largest positive value (for 8 bits, -128 counts as magnitude 127).
- R7: With `NV <= P`, `in_ready` is held high and `out_valid` rises on the same edge that accepts the input. With `NV > P`, `in_ready` falls after acceptance, and `out_valid` is high in the cycle after the (`NV/P`+1)-th rising edge that follows the accepting edge, with `in_ready` high again in that cycle.
- R8: The output is a maximum-likelihood word: among all even-parity words, none has a smaller total magnitude over the positions where it disagrees with the hard decisions.
- R9: After reset, `out_valid` is low. Each accepted vector produces exactly one `out_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | LLR vector is present |
| in_ready | output | 1 | Block can accept a vector |
| in_llr | input | NV*LLR_W | Packed signed LLRs, entry i in bits i*LLR_W upward |
| out_valid | output | 1 | Codeword estimate is valid this cycle |
| out_code | output | NV | Codeword estimate, bit i for LLR i |

## Verification
The assertions check on every cycle that each emitted word has even parity, that it differs from the captured hard decisions in no more than one position, that the output arrives exactly the configured number of cycles after acceptance, and that the block stays busy and pulses once per vector. Only the bench's scenarios can show that the inverted bit is the least reliable one. These scenarios cover lowest-index tie breaking inside a scan chunk and across chunks, saturation of the most negative value, and agreement with an exhaustive search over all even-parity words.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int unsigned SPC_FW = 16;

    typedef logic [SPC_FW-1:0] spc_mag_t;

    typedef struct packed {
        spc_mag_t              mag;
        logic [SPC_FW-1:0]     idx;
        logic                  par;
    } spc_cand_t;

    typedef enum logic [1:0] {
        SPC_IDLE = 2'd0,
        SPC_SCAN = 2'd1,
        SPC_FIX  = 2'd2
    } spc_state_e;

    localparam spc_cand_t SPC_CAND_INIT = '{mag: '1, idx: '0, par: 1'b0};

    // Magnitude of a sign-extended LLR of width w, clipped to the largest positive w-bit value.
    function automatic spc_mag_t spc_sat_mag(input logic signed [SPC_FW-1:0] x,
                                             input int unsigned w);
        spc_mag_t lim;
        spc_mag_t a;
        lim = SPC_FW'((32'd1 << (w - 1)) - 32'd1);
        a   = x[SPC_FW-1] ? spc_mag_t'(-x) : spc_mag_t'(x);
        return (a > lim) ? lim : a;
    endfunction

    // Select the smaller magnitude; 'lo' covers lower indices and wins ties.
    function automatic spc_cand_t spc_pick(input spc_cand_t lo, input spc_cand_t hi);
        spc_cand_t r;
        r     = (hi.mag < lo.mag) ? hi : lo;
        r.par = lo.par ^ hi.par;
        return r;
    endfunction

endpackage

// File: rtl/spc_hard.sv
module spc_hard #(
    parameter int unsigned NV    = 8,
    parameter int unsigned LLR_W = 8
) (
    input  logic [NV*LLR_W-1:0] llr,
    output logic [NV-1:0]       hard
);
    for (genvar i = 0; i < NV; i++) begin : g_bit
        assign hard[i] = llr[i*LLR_W + LLR_W - 1];
    end
endmodule

// File: rtl/spc_minsel.sv
module spc_minsel
    import spc_pkg::*;
#(
    parameter int unsigned W     = 4,
    parameter int unsigned LLR_W = 8
) (
    input  logic [W*LLR_W-1:0] llr,
    input  logic [SPC_FW-1:0]  base,
    output spc_cand_t          best
);
    // Heap-ordered tree: leaves at W-1..2W-2, root at 0.
    spc_cand_t node [2*W-1];

    for (genvar i = 0; i < W; i++) begin : g_leaf
        logic signed [LLR_W-1:0] v;
        assign v = llr[i*LLR_W +: LLR_W];
        assign node[W-1+i] = '{
            mag: spc_sat_mag(SPC_FW'(v), LLR_W),
            idx: base + SPC_FW'(i),
            par: v[LLR_W-1]
        };
    end

    for (genvar j = 0; j < W - 1; j++) begin : g_node
        assign node[j] = spc_pick(node[2*j+1], node[2*j+2]);
    end

    assign best = node[0];
endmodule

// File: rtl/spc_flip.sv
module spc_flip
    import spc_pkg::*;
#(
    parameter int unsigned NV = 8
) (
    input  logic [NV-1:0]     hard,
    input  logic              flip,
    input  logic [SPC_FW-1:0] idx,
    output logic [NV-1:0]     code
);
    for (genvar i = 0; i < NV; i++) begin : g_bit
        assign code[i] = hard[i] ^ (flip && (idx == SPC_FW'(i)));
    end
endmodule

// File: rtl/spc_decoder.sv
module spc_decoder
    import spc_pkg::*;
#(
    parameter int unsigned NV    = 8,
    parameter int unsigned P     = 4,
    parameter int unsigned LLR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NV*LLR_W-1:0] in_llr,
    output logic                out_valid,
    output logic [NV-1:0]       out_code
);
    localparam int unsigned LANES  = (NV <= P) ? NV : P;
    localparam int unsigned CHUNKS = NV / LANES;
    localparam int unsigned SLICE  = LANES * LLR_W;

    if (CHUNKS == 1) begin : g_single
        spc_cand_t       c_best;
        logic [NV-1:0]   c_hard;
        logic [NV-1:0]   c_code;

        spc_minsel #(.W(LANES), .LLR_W(LLR_W)) u_sel (
            .llr  (in_llr),
            .base ('0),
            .best (c_best)
        );
        spc_hard #(.NV(NV), .LLR_W(LLR_W)) u_hard (
            .llr  (in_llr),
            .hard (c_hard)
        );
        spc_flip #(.NV(NV)) u_flip (
            .hard (c_hard),
            .flip (c_best.par),
            .idx  (c_best.idx),
            .code (c_code)
        );

        assign in_ready = 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_code  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_code <= c_code;
            end
        end
    end else begin : g_multi
        localparam int unsigned CNT_W = $clog2(CHUNKS);

        spc_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [NV*LLR_W-1:0] llr_q;
        spc_cand_t           best_q;
        spc_cand_t           c_best;
        spc_cand_t           merged;
        logic [SLICE-1:0]    c_slice;
        logic [NV-1:0]       c_hard;
        logic [NV-1:0]       c_code;

        assign c_slice = llr_q[int'(cnt)*SLICE +: SLICE];

        spc_minsel #(.W(LANES), .LLR_W(LLR_W)) u_sel (
            .llr  (c_slice),
            .base (SPC_FW'(cnt) * SPC_FW'(LANES)),
            .best (c_best)
        );
        spc_hard #(.NV(NV), .LLR_W(LLR_W)) u_hard (
            .llr  (llr_q),
            .hard (c_hard)
        );
        spc_flip #(.NV(NV)) u_flip (
            .hard (c_hard),
            .flip (best_q.par),
            .idx  (best_q.idx),
            .code (c_code)
        );

        // Earlier chunks hold lower indices, so the stored candidate wins ties.
        assign merged   = spc_pick(best_q, c_best);
        assign in_ready = (state == SPC_IDLE);

        always_ff @(posedge clk) begin
            if (rst) begin
                state     <= SPC_IDLE;
                cnt       <= '0;
                llr_q     <= '0;
                best_q    <= SPC_CAND_INIT;
                out_valid <= 1'b0;
                out_code  <= '0;
            end else begin
                out_valid <= 1'b0;
                case (state)
                    SPC_IDLE: begin
                        if (in_valid) begin
                            llr_q  <= in_llr;
                            cnt    <= '0;
                            best_q <= SPC_CAND_INIT;
                            state  <= SPC_SCAN;
                        end
                    end
                    SPC_SCAN: begin
                        best_q <= merged;
                        cnt    <= cnt + 1'b1;
                        if (cnt == CNT_W'(CHUNKS - 1)) state <= SPC_FIX;
                    end
                    SPC_FIX: begin
                        out_code  <= c_code;
                        out_valid <= 1'b1;
                        state     <= SPC_IDLE;
                    end
                    default: state <= SPC_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/spc_decoder_chk.sv
module spc_decoder_chk
    import spc_pkg::*;
#(
    parameter int unsigned NV    = 8,
    parameter int unsigned P     = 4,
    parameter int unsigned LLR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [NV*LLR_W-1:0] in_llr,
    input logic                out_valid,
    input logic [NV-1:0]       out_code
);
    localparam int unsigned LANES  = (NV <= P) ? NV : P;
    localparam int unsigned CHUNKS = NV / LANES;
    localparam int unsigned LAT    = (CHUNKS == 1) ? 1 : CHUNKS + 2;

    logic [NV-1:0] in_sign;
    logic [NV-1:0] cap_hard;
    logic [7:0]    lat_cnt;

    always_comb begin
        for (int i = 0; i < NV; i++) in_sign[i] = in_llr[i*LLR_W + LLR_W - 1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_hard <= '0;
            lat_cnt  <= '0;
        end else if (in_valid && in_ready) begin
            cap_hard <= in_sign;
            lat_cnt  <= 8'd1;
        end else if (lat_cnt != 8'd0 && lat_cnt != 8'hFF) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    p_even_parity_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (^out_code) == 1'b0);

    p_single_flip_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_code ^ cap_hard) <= 1);

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lat_cnt == 8'(LAT));

    if (CHUNKS > 1) begin : g_multi_chk
        p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> !in_ready);

        p_ready_with_output_r7: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> in_ready);

        p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
            out_valid |=> !out_valid);
    end else begin : g_single_chk
        p_always_ready_r7: assert property (@(posedge clk) disable iff (rst)
            in_ready);
    end
endmodule

bind spc_decoder spc_decoder_chk #(.NV(NV), .P(P), .LLR_W(LLR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_llr    (in_llr),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/tb_spc_decoder.sv
`timescale 1ns/1ps
module tb_spc_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Main instance scans in two chunks; second instance decodes in one pass.
    logic        m_valid = 1'b0, m_ready, m_out_valid;
    logic [63:0] m_llr = '0;
    logic [7:0]  m_code;
    logic        s_valid = 1'b0, s_ready, s_out_valid;
    logic [31:0] s_llr = '0;
    logic [3:0]  s_code;

    spc_decoder #(.NV(8), .P(4), .LLR_W(8)) dut (
        .clk(clk), .rst(rst), .in_valid(m_valid), .in_ready(m_ready),
        .in_llr(m_llr), .out_valid(m_out_valid), .out_code(m_code)
    );
    spc_decoder #(.NV(4), .P(4), .LLR_W(8)) dut_short (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready),
        .in_llr(s_llr), .out_valid(s_out_valid), .out_code(s_code)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic signed [7:0] stim [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mag_of(input logic signed [7:0] v);
        if (v == -8'sd128) return 127;
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    function automatic logic [7:0] hard_of(input int n);
        logic [7:0] h = '0;
        for (int i = 0; i < n; i++) h[i] = (stim[i] < 0);
        return h;
    endfunction

    function automatic logic [7:0] exp_code(input int n);
        logic [7:0] h = hard_of(n);
        int best = 0;
        for (int i = 1; i < n; i++) if (mag_of(stim[i]) < mag_of(stim[best])) best = i;
        if (^h) h[best] = ~h[best];
        return h;
    endfunction

    function automatic int cost_of(input logic [7:0] w, input int n);
        logic [7:0] h = hard_of(n);
        int c = 0;
        for (int i = 0; i < n; i++) if (w[i] != h[i]) c += mag_of(stim[i]);
        return c;
    endfunction

    function automatic int ml_cost(input int n);
        int best = 1 << 30;
        for (int w = 0; w < (1 << n); w++) begin
            if (^(8'(w)) == 1'b0 && cost_of(8'(w), n) < best) best = cost_of(8'(w), n);
        end
        return best;
    endfunction

    task automatic run_vec(input bit sel, input string req);
        int n = sel ? 4 : 8;
        int exp_lat = sel ? 1 : 4;
        int lat;
        logic [7:0] got, exp;
        @(negedge clk);
        while (!(sel ? s_ready : m_ready)) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (sel) s_llr[i*8 +: 8] = stim[i];
            else     m_llr[i*8 +: 8] = stim[i];
        end
        if (sel) s_valid = 1'b1; else m_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        m_valid = 1'b0;
        lat = 1;
        if (!sel) chk(m_ready == 1'b0, "R7", "ready while busy", int'(m_ready), 0);
        while (!(sel ? s_out_valid : m_out_valid) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R7", "latency", lat, exp_lat);
        if (!sel) chk(m_ready == 1'b1, "R7", "ready with output", int'(m_ready), 1);
        got = sel ? {4'b0, s_code} : m_code;
        exp = exp_code(n);
        chk(got == exp, req, "codeword", int'(got), int'(exp));
        chk(^got == 1'b0, "R2", "parity", int'(^got), 0);
        chk(cost_of(got, n) == ml_cost(n), "R8", "ml cost", cost_of(got, n), ml_cost(n));
        @(negedge clk);
        chk((sel ? s_out_valid : m_out_valid) == 1'b0, "R9", "pulse width",
            int'(sel ? s_out_valid : m_out_valid), 0);
    endtask

    task automatic fill(input int a0, a1, a2, a3, a4, a5, a6, a7);
        stim[0] = 8'(a0); stim[1] = 8'(a1); stim[2] = 8'(a2); stim[3] = 8'(a3);
        stim[4] = 8'(a4); stim[5] = 8'(a5); stim[6] = 8'(a6); stim[7] = 8'(a7);
    endtask

    initial begin
        void'($urandom(32'd20181016));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(m_out_valid == 1'b0, "R9", "reset out_valid", int'(m_out_valid), 0);
        chk(s_out_valid == 1'b0, "R9", "reset short out_valid", int'(s_out_valid), 0);
        chk(m_ready == 1'b1, "R7", "reset ready", int'(m_ready), 1);

        fill(0, -3, -3, 10, 20, 30, 40, 50);         run_vec(1'b0, "R1");
        fill(9, 8, 7, 6, 5, 4, 3, 2);                run_vec(1'b0, "R3");
        fill(30, 25, -20, 40, 50, 3, 60, 70);        run_vec(1'b0, "R4");
        fill(30, 25, -20, 40, 50, 60, 70, 2);        run_vec(1'b0, "R4");
        fill(-5, 5, 5, 5, 5, 5, 5, 5);               run_vec(1'b0, "R5");
        fill(20, 4, 30, 40, -50, 4, 60, 70);         run_vec(1'b0, "R5");
        fill(-128, 127, 127, 127, 127, 127, 127, 127); run_vec(1'b0, "R6");
        fill(1, -1, 1, 1, 0, 0, 0, 0);               run_vec(1'b1, "R5");
        fill(-128, 127, 127, 127, 0, 0, 0, 0);       run_vec(1'b1, "R6");
        fill(-7, -6, 12, 13, 0, 0, 0, 0);            run_vec(1'b1, "R3");

        for (int k = 0; k < 120; k++) begin
            for (int i = 0; i < 8; i++) begin
                if ($urandom_range(0, 3) == 0) stim[i] = 8'(int'($urandom_range(0, 6)) - 3);
                else                           stim[i] = 8'($urandom_range(0, 255));
            end
            run_vec(k[0], "R4");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule